// File: doc/BRIEF.md
# Serial memory status and write-guard unit

This unit keeps the status byte of a serial nonvolatile memory and rules on every write that the command decoder asks for. A front end that has already parsed the serial stream raises one-cycle pulses for write-enable, write-disable, status-update (with its data byte), array-write start and cycle completion, together with the array address of the write. The unit answers each array write and each status update with a one-cycle grant or deny pulse, and it reports the status byte and a busy flag.

Three nonvolatile bits decide what may be written. A two-bit block-guard field fences off the upper quarter, the upper half or all of the array. A lock bit combines with an external write-guard pin (active low) to freeze the status byte itself. A volatile enable latch must be set before any write, and it clears itself when the cycle ends. The timing of the cycle belongs to the caller, which signals completion with a done pulse.

Top module: `wp_status_unit`

## Requirements
- R1: `status_o` places the lock bit at bit 7, the guard field at bits 3:2, the enable latch at bit 1 and the in-progress flag at bit 0. Bits 6:4 always read 0.
- R2: A write-enable pulse sets bit 1 and a write-disable pulse clears it. The change is visible after the next clock edge.
- R3: An array write or a status update that arrives while bit 1 is 0 is denied and leaves the status byte unchanged.
- R4: The guard field selects the denied addresses. 00 denies none. 01 denies addresses whose two top bits are 11 (0x18000 to 0x1FFFF at the default width). 10 denies addresses whose top bit is 1 (0x10000 to 0x1FFFF). 11 denies all of them. A denied write keeps bit 1 set.
- R5: A granted request sets bit 0 and `busy_o` at the same edge that raises the grant pulse. A done pulse while busy clears both bit 0 and bit 1.
- R6: A granted status update takes only data bits 7, 3 and 2. The new values appear at the done pulse that ends its cycle, and until then the old values remain.
- R7: When bit 7 is 1 and `wp_ni` is low, status updates are denied. When `wp_ni` is high, or bit 7 is 0, only bit 1 gates a status update.
- R8: While bit 0 is 1, array writes and status updates are denied, and write-enable and write-disable pulses have no effect.
- R9: Reset clears bits 1 and 0 and keeps bits 7, 3 and 2. These three bits start at 0 at power-up.
- R10: Each array write or status update gets exactly one grant or deny pulse, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable command pulse |
| wrsr_i | input | 1 | Status-update command pulse |
| wrsr_data_i | input | 8 | Status-update data byte |
| wr_start_i | input | 1 | Array-write request pulse |
| wr_addr_i | input | ADDR_W | Target address of the array write |
| cyc_done_i | input | 1 | End of the current write cycle |
| wp_ni | input | 1 | External write-guard pin, active low |
| status_o | output | 8 | Status byte |
| wr_grant_o | output | 1 | Array write accepted |
| wr_deny_o | output | 1 | Array write rejected |
| sr_grant_o | output | 1 | Status update accepted |
| sr_deny_o | output | 1 | Status update rejected |
| busy_o | output | 1 | Write cycle in progress |

## Verification
Array writes are aimed just below and just above each boundary of the guard field (0x17FFF/0x18000 and 0x0FFFF/0x10000), and at the lowest and highest addresses. This separates an off-by-one region decode from a correct one. Status updates are tried with a full-ones byte, which shows that the writable bits are masked. They are also tried with the lock bit set and the pin toggled, which tells the hardware lock apart from the software lock. Commands sent during a busy cycle, and a reset after the guard bits have been programmed, show whether the busy and retention rules hold.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  typedef struct packed {
    logic       lock;
    logic [1:0] guard;
  } nv_bits_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_WRDI,
    CMD_WRSR,
    CMD_WRITE
  } cmd_e;

  localparam int unsigned LOCK_POS  = 7;
  localparam int unsigned GUARD_POS = 2;
  localparam int unsigned WEL_POS   = 1;
  localparam int unsigned WIP_POS   = 0;
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_status_pkg::*;
(
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic wrsr_i,
  input  logic wr_start_i,
  output cmd_e cmd_o
);
  // fixed priority when pulses collide: array write, status, disable, enable
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_start_i)  cmd_o = CMD_WRITE;
    else if (wrsr_i) cmd_o = CMD_WRSR;
    else if (wrdi_i) cmd_o = CMD_WRDI;
    else if (wren_i) cmd_o = CMD_WREN;
  end
endmodule

// File: rtl/wp_range_check.sv
module wp_range_check #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [1:0]        guard_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic top_quarter, top_half;
  assign top_quarter = &addr_i[TOP -: 2];
  assign top_half    = addr_i[TOP];

  always_comb begin
    unique case (guard_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = top_quarter;
      2'b10:   hit_o = top_half;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_status_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_wel_i,
  input  logic     clr_wel_i,
  input  logic     start_i,
  input  logic     sr_cyc_i,
  input  nv_bits_t sr_new_i,
  input  logic     done_i,
  output logic     wel_o,
  output logic     wip_o,
  output nv_bits_t nv_o
);
  logic     wel_q, wip_q, pend_q;
  nv_bits_t pend_nv_q;
  nv_bits_t nv_q = '0; // nonvolatile: power-up value only, untouched by reset
  logic     finish;

  assign finish = done_i & wip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      wip_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_nv_q <= '0;
    end else begin
      if (finish) begin
        wip_q  <= 1'b0;
        wel_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (start_i) begin
        wip_q <= 1'b1;
        if (sr_cyc_i) begin
          pend_q    <= 1'b1;
          pend_nv_q <= sr_new_i;
        end
      end else if (set_wel_i) begin
        wel_q <= 1'b1;
      end else if (clr_wel_i) begin
        wel_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni && finish && pend_q) nv_q <= pend_nv_q;
  end

  assign wel_o = wel_q;
  assign wip_o = wip_q;
  assign nv_o  = nv_q;
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              cyc_done_i,
  input  logic              wp_ni,
  output logic [7:0]        status_o,
  output logic              wr_grant_o,
  output logic              wr_deny_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o,
  output logic              busy_o
);
  cmd_e     cmd;
  logic     wel, wip, addr_hit, hw_lock;
  logic     wr_ok, sr_ok, is_wr, is_sr;
  nv_bits_t nv, sr_new;
  logic     wr_grant_q, wr_deny_q, sr_grant_q, sr_deny_q;

  wp_cmd_decode u_dec (
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .wrsr_i    (wrsr_i),
    .wr_start_i(wr_start_i),
    .cmd_o     (cmd)
  );

  wp_range_check #(.ADDR_W(ADDR_W)) u_rng (
    .guard_i(nv.guard),
    .addr_i (wr_addr_i),
    .hit_o  (addr_hit)
  );

  assign is_wr   = (cmd == CMD_WRITE);
  assign is_sr   = (cmd == CMD_WRSR);
  assign hw_lock = nv.lock & ~wp_ni;
  assign wr_ok   = is_wr & ~wip & wel & ~addr_hit;
  assign sr_ok   = is_sr & ~wip & wel & ~hw_lock;
  assign sr_new  = '{lock:  wrsr_data_i[LOCK_POS],
                     guard: wrsr_data_i[GUARD_POS +: 2]};

  wp_status_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wel_i(cmd == CMD_WREN && !wip),
    .clr_wel_i(cmd == CMD_WRDI && !wip),
    .start_i  (wr_ok | sr_ok),
    .sr_cyc_i (sr_ok),
    .sr_new_i (sr_new),
    .done_i   (cyc_done_i),
    .wel_o    (wel),
    .wip_o    (wip),
    .nv_o     (nv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_grant_q <= 1'b0;
      wr_deny_q  <= 1'b0;
      sr_grant_q <= 1'b0;
      sr_deny_q  <= 1'b0;
    end else begin
      wr_grant_q <= wr_ok;
      wr_deny_q  <= is_wr & ~wr_ok;
      sr_grant_q <= sr_ok;
      sr_deny_q  <= is_sr & ~sr_ok;
    end
  end

  assign status_o   = {nv.lock, 3'b000, nv.guard, wel, wip};
  assign wr_grant_o = wr_grant_q;
  assign wr_deny_o  = wr_deny_q;
  assign sr_grant_o = sr_grant_q;
  assign sr_deny_o  = sr_deny_q;
  assign busy_o     = wip;
endmodule

// File: rtl/wp_status_unit_chk.sv
module wp_status_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cyc_done_i,
  input logic       wp_ni,
  input logic [7:0] status_o,
  input logic       wr_grant_o,
  input logic       wr_deny_o,
  input logic       sr_grant_o,
  input logic       sr_deny_o
);
  a_r1_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);

  a_r10_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_grant_o, wr_deny_o, sr_grant_o, sr_deny_o}) <= 1);

  a_r5_grant_sets_wip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_grant_o || sr_grant_o) |-> status_o[0]);

  a_r3_grant_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_grant_o || sr_grant_o) |-> $past(status_o[1]));

  a_r8_no_grant_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_grant_o || sr_grant_o) |-> !$past(status_o[0]));

  a_r7_hw_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_grant_o |-> !($past(status_o[7]) && !$past(wp_ni)));

  a_r6_nv_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cyc_done_i) |-> $stable({status_o[7], status_o[3:2]}));
endmodule

bind wp_status_unit wp_status_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cyc_done_i(cyc_done_i),
  .wp_ni     (wp_ni),
  .status_o  (status_o),
  .wr_grant_o(wr_grant_o),
  .wr_deny_o (wr_deny_o),
  .sr_grant_o(sr_grant_o),
  .sr_deny_o (sr_deny_o)
);

// File: tb/wp_status_unit_test.sv
module wp_status_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 17;

  // response codes: 0 write grant, 1 write deny, 2 status grant, 3 status deny
  typedef struct {
    string      tag;
    logic [3:0] resp;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0;
  logic [7:0]        wrsr_data_i = '0;
  logic              wr_start_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic              cyc_done_i = 1'b0;
  logic              wp_ni = 1'b1;
  logic [7:0]        status_o;
  logic              wr_grant_o, wr_deny_o, sr_grant_o, sr_deny_o, busy_o;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wp_status_unit #(.ADDR_W(ADDR_W)) uut (.*);

  // monitor: compare every response pulse against the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if ({sr_deny_o, sr_grant_o, wr_deny_o, wr_grant_o} != 4'b0) begin
        logic [3:0] got;
        got = {sr_deny_o, sr_grant_o, wr_deny_o, wr_grant_o};
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected response: got %b expected none", got);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (got !== e.resp) begin
            errors++;
            $display("FAIL %s response: got %b expected %b", e.tag, got, e.resp);
          end
        end
      end
    end
  end

  task automatic check_status(input logic [7:0] exp, input string tag);
    checks++;
    if (status_o !== exp || busy_o !== exp[0]) begin
      errors++;
      $display("FAIL %s status: got %h busy %b expected %h busy %b",
               tag, status_o, busy_o, exp, exp[0]);
    end
  endtask

  task automatic clear_in();
    wren_i = 0; wrdi_i = 0; wrsr_i = 0; wr_start_i = 0; cyc_done_i = 0;
  endtask

  task automatic do_wren();
    wren_i = 1; @(negedge clk_i); clear_in();
  endtask

  task automatic do_wrdi();
    wrdi_i = 1; @(negedge clk_i); clear_in();
  endtask

  task automatic do_done();
    cyc_done_i = 1; @(negedge clk_i); clear_in();
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input bit ok, input string tag);
    sb.push_back('{tag, ok ? 4'b0001 : 4'b0010});
    wr_addr_i = a; wr_start_i = 1; @(negedge clk_i); clear_in();
  endtask

  task automatic do_wrsr(input logic [7:0] d, input bit ok, input string tag);
    sb.push_back('{tag, ok ? 4'b0100 : 4'b1000});
    wrsr_data_i = d; wrsr_i = 1; @(negedge clk_i); clear_in();
  endtask

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check_status(8'h00, "R9 power-up");

    do_write(17'h00010, 0, "R3 write without enable");
    check_status(8'h00, "R3 state unchanged");
    do_wrsr(8'h8C, 0, "R3 status update without enable");
    check_status(8'h00, "R3 status unchanged");

    do_wren();
    check_status(8'h02, "R2 enable sets bit1");
    do_wrdi();
    check_status(8'h00, "R2 disable clears bit1");
    do_wren();

    do_write(17'h1FFFF, 1, "R4 guard 00 top address");
    check_status(8'h03, "R5 busy after grant");
    do_wrdi();
    check_status(8'h03, "R8 disable ignored while busy");
    do_write(17'h00000, 0, "R8 write while busy");
    do_wrsr(8'h00, 0, "R8 status update while busy");
    do_done();
    check_status(8'h00, "R5 done clears bit1 and bit0");
    do_done();
    check_status(8'h00, "R5 done while idle");

    do_wren();
    do_wrsr(8'hFF, 1, "R6 status update all ones");
    check_status(8'h03, "R6 old bits kept until done");
    do_done();
    check_status(8'h8C, "R1 R6 only bits 7,3,2 taken");

    do_wren();
    do_write(17'h00000, 0, "R4 guard 11 bottom address");
    check_status(8'h8E, "R4 denied write keeps bit1");

    wp_ni = 0;
    do_wrsr(8'h04, 0, "R7 lock with pin low");
    check_status(8'h8E, "R7 status unchanged");
    wp_ni = 1;
    do_wrsr(8'h04, 1, "R7 lock with pin high");
    do_done();
    check_status(8'h04, "R6 guard 01 committed");

    do_wren();
    do_write(17'h17FFF, 1, "R4 guard 01 below quarter");
    do_done();
    do_wren();
    do_write(17'h18000, 0, "R4 guard 01 quarter base");

    wp_ni = 0;
    do_wrsr(8'h08, 1, "R7 pin low with lock 0");
    wp_ni = 1;
    do_done();
    check_status(8'h08, "R6 guard 10 committed");
    do_wren();
    do_write(17'h0FFFF, 1, "R4 guard 10 below half");
    do_done();
    do_wren();
    do_write(17'h10000, 0, "R4 guard 10 half base");

    do_wrsr(8'h8C, 1, "R6 restore lock and guard");
    do_done();
    do_wren();
    check_status(8'h8E, "R2 enable before reset");
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check_status(8'h8C, "R9 reset keeps bits 7,3,2");

    repeat (2) @(negedge clk_i);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses: got %0d pending expected 0", sb.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule